// File: doc/BRIEF.md
# Serial Flash Streaming Reader

This block is a host-side master that pulls a run of bytes out of a page-organised serial flash using one continuous-read command. On a start pulse it lowers chip select and shifts out the read opcode 0xE8, then a 24-bit address, then four zero filler bytes. After that it keeps clocking and collects one byte from the serial input for every eight clocks, until the requested number of bytes has been returned. The flash advances its own internal address, so the master sends no further addresses once the data begins.

The caller gives a 12-bit page number, a 9-bit byte offset, a byte count, a flag that selects the 256-byte page geometry, and the idle clock polarity (SPI mode 0 or mode 3). Received bytes leave on an 8-bit port with a valid/ready handshake. When the consumer holds ready low, the serial clock stops between two bytes and never inside one. The serial clock half-period is a parameter counted in system clock cycles.

Top module: `sflash_stream_rd`

## Requirements
- R1: While reset is held and on the first cycle after it, cs_n_o is 1, busy_o is 0, rd_valid_o is 0 and mosi_o is 0.
- R2: The first eight bits on mosi_o after chip select falls are 0xE8, sent most significant bit first. mosi_o is read by the target on rising SCK edges.
- R3: With pow2_i = 0, the 24 bits after the opcode are {3'b000, page_i[11:0], offset_i[8:0]}, sent MSB first.
- R4: With pow2_i = 1, the 24 address bits are {4'b0000, page_i[11:0], offset_i[7:0]}, and offset_i[8] has no effect.
- R5: The 32 bits after the address are all zero. Bit k (k from 0) read on miso_i at a rising SCK edge after the 64th one belongs to data byte k/8, at bit position 7 - k%8. The bytes appear on rd_data_o in the order received.
- R6: A start with count_i = N > 0 produces exactly 64 + 8*N rising SCK edges while chip select is low, and exactly N handshakes. A start with count_i = 0 is ignored: chip select stays high and busy_o stays low.
- R7: While chip select is high, SCK rests at the level of cpol_i (0 for mode 0, 1 for mode 3), and it is at that level when chip select falls. Inside a byte, successive rising edges are 2*SCK_HALF system cycles apart.
- R8: mosi_o changes only on a cycle where SCK is low, so that it changes together with, or after, a falling SCK edge.
- R9: When rd_valid_o is 1 and rd_ready_i stays 0 while the next byte is complete, SCK holds high after that byte's eighth rising edge and gives no further edges until the output is taken.
- R10: Chip select stays high for at least 2*SCK_HALF cycles between two transfers. A start pulse while busy_o is high, or during that high gap, is ignored.
- R11: busy_o equals the inverse of cs_n_o in every cycle.
- R12: While rd_valid_o is 1 and rd_ready_i is 0, rd_valid_o stays 1 and rd_data_o keeps its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpol_i | input | 1 | Idle SCK level: 0 = mode 0, 1 = mode 3 |
| pow2_i | input | 1 | 1 selects the 256-byte page address layout |
| page_i | input | 12 | Page number |
| offset_i | input | 9 | Starting byte within the page |
| count_i | input | CNT_W | Number of bytes to read |
| start_i | input | 1 | One-cycle request to begin a transfer |
| busy_o | output | 1 | High while chip select is low |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o holds a byte |
| rd_ready_i | input | 1 | Consumer accepts the byte |

## Verification
The assertions place no limits on rd_ready_i, which may change on any cycle. They do assume that start_i is a single-cycle pulse, and that the flash changes miso_i only on falling SCK edges, so the value is settled when it is sampled on the rise. The bench's flash model drives miso_i only on falling edges. The bench sets cpol_i and the request fields several idle cycles before each start. It draws byte counts from 1 to 24 and adds a directed zero-count request, start pulses issued while busy and during the chip-select gap, and a long ready-low stall.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam logic [7:0] RD_OPCODE  = 8'hE8;
    localparam int         HDR_BYTES  = 8;
    localparam int         HDR_BITS   = HDR_BYTES * 8;
    localparam int         ADDR_BITS  = 24;
    localparam int         FILL_BITS  = HDR_BITS - 8 - ADDR_BITS;
    localparam int         PAGE_W     = 12;
    localparam int         OFF_W      = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LO,
        ST_HI,
        ST_DELIVER,
        ST_TAIL,
        ST_GAP
    } sfr_state_e;

    typedef struct packed {
        logic              pow2;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } sfr_req_t;

    // Right-aligned page/byte address; the geometry flag decides the split.
    function automatic logic [ADDR_BITS-1:0] pack_addr(sfr_req_t r);
        logic [ADDR_BITS-1:0] a;
        a = '0;
        if (r.pow2)
            a[PAGE_W+7:0] = {r.page, r.off[7:0]};
        else
            a[PAGE_W+OFF_W-1:0] = {r.page, r.off};
        return a;
    endfunction

    function automatic logic [HDR_BITS-1:0] build_header(sfr_req_t r);
        return {RD_OPCODE, pack_addr(r), {FILL_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/sfr_clkdiv.sv
module sfr_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !en_i)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift
    import sfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [HDR_BITS-1:0] hdr_i,
    input  logic                shift_i,
    input  logic                sample_i,
    input  logic                miso_i,
    output logic                mosi_o,
    output logic [7:0]          rx_o
);
    logic [HDR_BITS-1:0] tx_q;
    logic                mosi_q;
    logic [7:0]          rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            mosi_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            if (load_i) begin
                tx_q <= hdr_i;
            end else if (shift_i) begin
                mosi_q <= tx_q[HDR_BITS-1];
                tx_q   <= {tx_q[HDR_BITS-2:0], 1'b0};
            end
            if (sample_i)
                rx_q <= {rx_q[6:0], miso_i};
        end
    end

    assign mosi_o = mosi_q;
    assign rx_o   = rx_q;
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
    import sfr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             cpol_i,
    input  logic             tick_i,
    input  logic             out_free_i,
    output logic             div_en_o,
    output logic             load_o,
    output logic             shift_o,
    output logic             sample_o,
    output logic             deliver_o,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             busy_o
);
    localparam int HW = $clog2(HDR_BYTES);

    sfr_state_e       state_q;
    logic [2:0]       bit_q;
    logic [HW-1:0]    hdr_q;
    logic             in_hdr_q;
    logic [CNT_W-1:0] remain_q;
    logic             mode_q;
    logic             gap2_q;
    logic             cs_q;
    logic             sck_q;

    logic accept, lo_end, hi_end, byte_end, data_end, deliver, last_byte, enter_lo;

    always_comb begin
        accept    = (state_q == ST_IDLE) && start_i && (count_i != '0);
        lo_end    = (state_q == ST_LO) && tick_i;
        hi_end    = (state_q == ST_HI) && tick_i;
        byte_end  = hi_end && (bit_q == 3'd0);
        data_end  = byte_end && !in_hdr_q;
        deliver   = (state_q == ST_DELIVER) && out_free_i;
        last_byte = (remain_q == CNT_W'(1));
        enter_lo  = ((state_q == ST_SETUP) && tick_i)
                  || (hi_end && !data_end)
                  || (deliver && !last_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            bit_q    <= 3'd7;
            hdr_q    <= '0;
            in_hdr_q <= 1'b1;
            remain_q <= '0;
            mode_q   <= 1'b0;
            gap2_q   <= 1'b0;
            cs_q     <= 1'b1;
            sck_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sck_q <= cpol_i;
                    if (accept) begin
                        mode_q   <= cpol_i;
                        cs_q     <= 1'b0;
                        remain_q <= count_i;
                        bit_q    <= 3'd7;
                        hdr_q    <= '0;
                        in_hdr_q <= 1'b1;
                        state_q  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick_i) begin
                        sck_q   <= 1'b0;
                        state_q <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (tick_i) begin
                        sck_q   <= 1'b1;
                        state_q <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (tick_i) begin
                        bit_q <= bit_q - 3'd1;
                        if (byte_end && in_hdr_q) begin
                            hdr_q <= hdr_q + 1'b1;
                            if (hdr_q == HW'(HDR_BYTES - 1))
                                in_hdr_q <= 1'b0;
                        end
                        if (data_end) begin
                            state_q <= ST_DELIVER;
                        end else begin
                            sck_q   <= 1'b0;
                            state_q <= ST_LO;
                        end
                    end
                end
                ST_DELIVER: begin
                    if (out_free_i) begin
                        remain_q <= remain_q - 1'b1;
                        if (last_byte) begin
                            sck_q   <= mode_q;
                            state_q <= ST_TAIL;
                        end else begin
                            sck_q   <= 1'b0;
                            state_q <= ST_LO;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick_i) begin
                        cs_q    <= 1'b1;
                        gap2_q  <= 1'b0;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick_i) begin
                        if (gap2_q)
                            state_q <= ST_IDLE;
                        else
                            gap2_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign div_en_o  = (state_q == ST_SETUP) || (state_q == ST_LO) || (state_q == ST_HI)
                     || (state_q == ST_TAIL) || (state_q == ST_GAP);
    assign load_o    = accept;
    assign shift_o   = enter_lo;
    assign sample_o  = lo_end;
    assign deliver_o = deliver;
    assign cs_n_o    = cs_q;
    assign sck_o     = sck_q;
    assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_GAP);
endmodule

// File: rtl/sflash_stream_rd.sv
module sflash_stream_rd
    import sfr_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpol_i,
    input  logic              pow2_i,
    input  logic [11:0]       page_i,
    input  logic [8:0]        offset_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i
);
    sfr_req_t            req;
    logic [HDR_BITS-1:0] hdr;
    logic                tick, div_en, load, shift, sample, deliver, out_free;
    logic [7:0]          rx_byte;
    logic [7:0]          data_q;
    logic                valid_q;

    assign req      = '{pow2: pow2_i, page: page_i, off: offset_i};
    assign hdr      = build_header(req);
    assign out_free = !valid_q || rd_ready_i;

    sfr_clkdiv #(.HALF(SCK_HALF)) u_div (
        .clk    (clk),
        .rst    (rst),
        .en_i   (div_en),
        .tick_o (tick)
    );

    sfr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .count_i    (count_i),
        .cpol_i     (cpol_i),
        .tick_i     (tick),
        .out_free_i (out_free),
        .div_en_o   (div_en),
        .load_o     (load),
        .shift_o    (shift),
        .sample_o   (sample),
        .deliver_o  (deliver),
        .cs_n_o     (cs_n_o),
        .sck_o      (sck_o),
        .busy_o     (busy_o)
    );

    sfr_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .hdr_i    (hdr),
        .shift_i  (shift),
        .sample_i (sample),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (deliver) begin
            valid_q <= 1'b1;
            data_q  <= rx_byte;
        end else if (rd_ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk #(
    parameter int HALF = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       busy,
    input logic       sck,
    input logic       mosi,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    localparam int GW = 16;

    logic [GW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '1;
        else if (!cs_n)
            hi_run <= '0;
        else if (hi_run != '1)
            hi_run <= hi_run + 1'b1;
    end

    assert_busy_cs_R11: assert property (@(posedge clk) disable iff (rst)
        busy == !cs_n);

    assert_mosi_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> !sck);

    assert_hold_out_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_cs_gap_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> hi_run >= GW'(2 * HALF));

endmodule

bind sflash_stream_rd sfr_chk #(.HALF(SCK_HALF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n_o),
    .busy      (busy_o),
    .sck       (sck_o),
    .mosi      (mosi_o),
    .out_valid (rd_valid_o),
    .out_ready (rd_ready_i),
    .out_data  (rd_data_o)
);

// File: tb/sim_sflash_stream_rd.sv
module sim_sflash_stream_rd;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpol = 1'b0, pow2 = 1'b0, start = 1'b0;
    logic [11:0]      page = '0;
    logic [8:0]       off = '0;
    logic [CNT_W-1:0] cnt = '0;
    logic             busy, cs_n, sck, mosi;
    logic             miso = 1'b0;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             rd_ready = 1'b0;

    int checks = 0, errors = 0;
    int rmode = 1;
    logic [7:0] got [0:255];
    int got_n = 0;

    sflash_stream_rd #(.SCK_HALF(HALF), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .cpol_i(cpol), .pow2_i(pow2), .page_i(page),
        .offset_i(off), .count_i(cnt), .start_i(start), .busy_o(busy),
        .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] exp_addr(logic p2, logic [11:0] pg, logic [8:0] of);
        int a;
        if (p2) a = int'(pg) * 256 + int'(of) % 256;
        else    a = int'(pg) * 512 + int'(of);
        return a[23:0];
    endfunction

    function automatic logic [7:0] slave_byte(logic [23:0] a, int k);
        logic [31:0] t;
        t = {8'h0, a} * 32'd97 + k * 31 + ({8'h0, a} >> 5);
        return t[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Flash model: captures header bits on rising SCK, serves data on falling SCK.
    int          s_rise = 0, last_rise = 0;
    logic [63:0] s_hdr = '0, last_hdr = '0;
    bit          s_active = 0, per_bad = 0;
    time         last_t = 0;

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            if (s_active) begin
                last_rise = s_rise;
                last_hdr  = s_hdr;
                s_rise    = 0;
                s_hdr     = '0;
                s_active  = 0;
            end
        end else if (sck) begin
            s_active = 1;
            s_rise++;
            if (s_rise <= 64) s_hdr = {s_hdr[62:0], mosi};
            if (((s_rise - 1) % 8) != 0 && ($time - last_t) != time'(2 * HALF * CLK_PERIOD))
                per_bad = 1;
            last_t = $time;
        end
    end

    always @(negedge sck) begin
        if (!cs_n && s_rise >= 64) begin
            logic [7:0] b;
            b    = slave_byte(s_hdr[55:32], (s_rise - 64) / 8);
            miso = b[7 - (s_rise - 64) % 8];
        end
    end

    // Consumer and protocol monitor, away from the active edge.
    int bad_busy = 0, bad_mosi = 0, bad_hold = 0, bad_gap = 0, bad_idle = 0;
    int cs_falls = 0, hi_run = 1000;
    logic p_mosi = 1'b0, p_valid = 1'b0, p_ready = 1'b0, p_cs = 1'b1;
    logic [7:0] p_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy == cs_n) bad_busy++;
            if (mosi != p_mosi && sck) bad_mosi++;
            if (p_valid && !p_ready && (!rd_valid || rd_data != p_data)) bad_hold++;
            if (cs_n) hi_run++;
            else begin
                if (p_cs) begin
                    cs_falls++;
                    if (hi_run < 2 * HALF) bad_gap++;
                    if (sck != cpol) bad_idle++;
                end
                hi_run = 0;
            end
        end
        case (rmode)
            0:       rd_ready = 1'($urandom % 2);
            1:       rd_ready = 1'b1;
            default: rd_ready = 1'b0;
        endcase
        if (!rst && rd_valid && rd_ready) begin
            got[got_n[7:0]] = rd_data;
            got_n++;
        end
        p_mosi  = mosi;
        p_valid = rd_valid;
        p_ready = rd_ready;
        p_data  = rd_data;
        p_cs    = cs_n;
    end

    task automatic run_txn(input logic [11:0] pg, input logic [8:0] of, input int n,
                           input logic p2, input logic cp, input int rm);
        int falls0;
        logic [23:0] ea;
        int nbad;
        @(negedge clk);
        cpol = cp; pow2 = p2; page = pg; off = of; cnt = CNT_W'(n);
        rmode = (rm == 2) ? 2 : rm;
        got_n = 0; per_bad = 0;
        repeat (3) @(negedge clk);
        chk(sck == cp, "R7 idle sck level", sck, cp);
        falls0 = cs_falls;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        page = ~pg; start = 1'b1; @(negedge clk); start = 1'b0; page = pg;
        if (rm == 2) begin
            repeat (300) @(negedge clk);
            if (n >= 2) begin
                chk(rd_valid == 1'b1, "R9 stalled valid", rd_valid, 1);
                chk(sck == 1'b1, "R9 sck held high", sck, 1);
                chk(s_rise == 64 + 16, "R9 rising edges frozen", s_rise, 80);
            end
            rmode = 0;
        end
        while (busy) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        while (rd_valid) @(negedge clk);
        repeat (2) @(negedge clk);
        ea = exp_addr(p2, pg, of);
        chk(last_hdr[63:56] == 8'hE8, "R2 opcode", last_hdr[63:56], 8'hE8);
        if (p2) chk(last_hdr[55:32] == ea, "R4 address", last_hdr[55:32], ea);
        else    chk(last_hdr[55:32] == ea, "R3 address", last_hdr[55:32], ea);
        chk(last_hdr[31:0] == 32'h0, "R5 filler bytes", last_hdr[31:0], 0);
        chk(last_rise == 64 + 8 * n, "R6 rising edge count", last_rise, 64 + 8 * n);
        chk(got_n == n, "R6 byte count", got_n, n);
        nbad = 0;
        for (int k = 0; k < n && k < 256; k++)
            if (got[k] != slave_byte(ea, k)) nbad++;
        chk(nbad == 0, "R5 data bytes", nbad, 0);
        chk(sck == cp, "R7 sck back at idle", sck, cp);
        chk(!per_bad, "R7 sck period", per_bad, 0);
        chk(cs_falls == falls0 + 1, "R10 extra starts ignored", cs_falls - falls0, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(rd_valid == 1'b0, "R1 valid after reset", rd_valid, 0);
        chk(mosi == 1'b0, "R1 mosi after reset", mosi, 0);

        run_txn(12'hFFF, 9'h1FF, 3, 1'b0, 1'b0, 1);
        run_txn(12'hABC, 9'h1FF, 4, 1'b1, 1'b1, 0);
        run_txn(12'h000, 9'h000, 1, 1'b0, 1'b1, 1);
        run_txn(12'h123, 9'h0F0, 5, 1'b0, 1'b0, 2);
        run_txn(12'h800, 9'h100, 6, 1'b1, 1'b1, 2);

        begin : zero_count
            int f0;
            @(negedge clk);
            cnt = '0; f0 = cs_falls;
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            chk(cs_falls == f0 && cs_n, "R6 zero count ignored", cs_falls - f0, 0);
            chk(busy == 1'b0, "R6 zero count not busy", busy, 0);
        end

        for (int i = 0; i < 20; i++) begin
            run_txn(12'($urandom), 9'($urandom), 1 + int'($urandom % 24),
                    1'($urandom), 1'($urandom), int'($urandom % 2));
        end

        chk(bad_busy == 0, "R11 busy vs cs_n", bad_busy, 0);
        chk(bad_mosi == 0, "R8 mosi changes with sck low", bad_mosi, 0);
        chk(bad_hold == 0, "R12 output held under stall", bad_hold, 0);
        chk(bad_gap == 0, "R10 chip select gap", bad_gap, 0);
        chk(bad_idle == 0, "R7 sck level at cs fall", bad_idle, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule